// File: doc/BRIEF.md
# SDRAM Refresh and Power-Mode Sequencer

This block produces the maintenance command stream of an SDRAM controller. A down-counting interval timer marks each point where a refresh is owed. The sequencer answers each one with a precharge of all banks, a guard gap of NOP cycles and then an auto-refresh. After that the memory sits idle with every bank closed, ready for the next row activation. If the access engine reports a transfer in flight, a refresh that falls due is held back until the engine goes quiet. The timer keeps running through that wait, so the long-run refresh rate does not drift.

Software controls the block through one write port. The port carries a clock-enable bit, a refresh-enable bit and the interval length. Clearing the clock-enable bit parks the memory. The refresh-enable bit, taken from the same write, picks the low-power mode: self-refresh when it is set, power-down when it is clear. In both cases a precharge-all and a gap come first, and the CKE pin falls in the cycle the entry command is issued. Setting the clock-enable bit again produces an exit command with CKE high. Clearing the refresh-enable bit also parks the timer at its reload value. A refresh owed from time spent asleep is issued as soon as the memory wakes.

Every command leaves on a one-hot bus with a valid/ready handshake and is held until it is accepted. A one-cycle overrun pulse flags an interval that expires while the previous refresh is still owed.

Top module: `sdram_rfsh_pm_seq`

## Requirements
- R1: With refresh enabled and interval N written at clock edge W, the owed refresh appears as PALL after edge W+N+1. The next valid command is REF, two cycles after PALL, with exactly one NOP cycle between them. Command bits are: bit 0 NOP, bit 1 PALL, bit 2 REF, bit 3 SREF, bit 4 PDWN, bit 5 EXIT.
- R2: The sequencer does not leave idle for a refresh while `xfer_busy` is high. A refresh deferred this way starts at the first edge where busy is low. The timer is not restarted by the deferral, so the next PALL comes at W+2N+1.
- R3: Clearing the clock-enable bit while refresh is enabled gives PALL, then one NOP cycle, then SREF.
- R4: Clearing the clock-enable bit in the same write that clears refresh-enable gives PALL, then one NOP cycle, then PDWN.
- R5: `cke_out` stays high through the PALL and NOP of an entry. It is low in the SREF/PDWN cycle and stays low while parked. Setting the clock-enable bit gives an EXIT command with `cke_out` high, then idle.
- R6: A refresh that falls due while parked is issued right after wake: PALL two cycles after EXIT, REF two cycles later. A park and wake inside one interval leaves the next PALL at W+N+1.
- R7: While refresh-enable is clear, no refresh is ever raised. Setting it again, even in the write that sets the clock-enable bit, starts a fresh interval counted from that write.
- R8: An expiry that comes while a refresh is still owed gives a one-cycle pulse on `rfsh_overrun`.
- R9: A command presented while `cmd_ready` is low stays on the bus unchanged. The sequence does not advance until the command is accepted.
- R10: After reset the bus shows NOP with `cmd_valid` low, `cke_out` is high, `rfsh_overrun` is low, and refresh is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_cke | input | 1 | Clock-enable bit for the memory |
| cfg_ref_en | input | 1 | Refresh enable / self-refresh select |
| cfg_interval | input | CNT_W | Refresh interval in clock cycles |
| xfer_busy | input | 1 | Access engine has a transfer in flight |
| cmd_ready | input | 1 | Command consumer accepts the bus |
| cmd_valid | output | 1 | A non-NOP command is presented |
| cmd_onehot | output | 6 | One-hot command code |
| cke_out | output | 1 | CKE pin level |
| rfsh_overrun | output | 1 | Pulse: interval expired with refresh still owed |

## Verification
The refresh path is driven from a table of interval and busy-length pairs. Some pairs have no busy at all, which gives the bare interval. Others hold busy past the expiry, which shows deferral. A third kind releases busy before the expiry, which must leave the first refresh on time. In every case the second PALL must still land at 2N+1. This separates a timer that keeps counting from one that restarts on the deferred refresh. Directed runs then cover:
- parking with the refresh-enable bit set and with it cleared in the same write, which tells self-refresh from power-down;
- sleeping across an expiry versus waking inside one interval;
- clearing refresh-enable while asleep and re-enabling it in the wake write;
- a held busy that makes the overrun pulse fire;
- a stalled `cmd_ready`.

// File: rtl/rpm_pkg.sv
// Shared types for the refresh and power-mode sequencer.
// Assumes: the command bus is one-hot over CMD_N codes, and the code index
// equals the bit position on the bus.
package rpm_pkg;

    localparam int CMD_N = 6;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_REF  = 3'd2,
        CMD_SREF = 3'd3,
        CMD_PDWN = 3'd4,
        CMD_EXIT = 3'd5
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_RPALL  = 4'd1,
        S_RGAP   = 4'd2,
        S_REF    = 4'd3,
        S_LPALL  = 4'd4,
        S_LGAP   = 4'd5,
        S_LENTER = 4'd6,
        S_SLEEP  = 4'd7,
        S_EXIT   = 4'd8
    } seq_state_e;

    // Map a command code onto its one-hot bus value.
    function automatic logic [CMD_N-1:0] cmd_to_onehot(input cmd_e c);
        logic [CMD_N-1:0] v;
        v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rpm_cfg_regs.sv
// Control register for the sequencer.
// Holds the clock-enable bit, the refresh-enable bit and the interval length.
// All three load together on each write strobe.
// Assumes: the writer always supplies all three fields.
module rpm_cfg_regs #(
    parameter int                 CNT_W          = 16,
    parameter logic [CNT_W-1:0]   RESET_INTERVAL = CNT_W'(1560)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_cke,
    input  logic             cfg_ref_en,
    input  logic [CNT_W-1:0] cfg_interval,
    output logic             cke_q,
    output logic             ref_en_q,
    output logic [CNT_W-1:0] interval_q
);

    // Capture a full control word on every write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q      <= 1'b1;
            ref_en_q   <= 1'b0;
            interval_q <= RESET_INTERVAL;
        end else if (cfg_wr) begin
            cke_q      <= cfg_cke;
            ref_en_q   <= cfg_ref_en;
            interval_q <= cfg_interval;
        end
    end

endmodule

// File: rtl/rpm_interval_timer.sv
// Refresh interval timer.
// Counts down while refresh is enabled and raises a one-cycle expiry each
// time the programmed interval has elapsed.
// While refresh is disabled it holds the reload value. A write that disables
// refresh, or that re-enables it from the disabled state, restarts it from the
// written interval. Writes that leave refresh enabled do not disturb the count.
// Assumes: an interval of 0 or 1 behaves as 1 cycle.
module rpm_interval_timer #(
    parameter int                 CNT_W          = 16,
    parameter logic [CNT_W-1:0]   RESET_INTERVAL = CNT_W'(1560)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_ref_en,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             ref_en_q,
    input  logic [CNT_W-1:0] interval_q,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;
    logic             restart;

    // A write that turns refresh off, or turns it back on, reloads the count.
    assign restart = cfg_wr && (!cfg_ref_en || !ref_en_q);

    // Expiry fires on the last cycle of each interval.
    assign expire = ref_en_q && (cnt <= CNT_W'(1));

    // Down-counter with reload on expiry and hold while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RESET_INTERVAL;
        end else if (restart) begin
            cnt <= cfg_interval;
        end else if (!ref_en_q) begin
            cnt <= interval_q;
        end else if (expire) begin
            cnt <= interval_q;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R7: with refresh off and no write, the count parks at the reload value.
    p_parked_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en_q && !cfg_wr) |=> (cnt == $past(interval_q)));

    // R1: an enabled, unexpired count steps down by one.
    p_counts_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en_q && !expire && !cfg_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/rpm_pending.sv
// Pending-refresh tracker.
// A one-bit flag is set by a timer expiry and cleared when the REF command is
// accepted. An expiry that lands on an already-set flag, without a REF being
// accepted in that cycle, produces a one-cycle overrun pulse.
// Assumes: expiry and REF acceptance are single-cycle strobes.
module rpm_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ref_fire,
    output logic pending_q,
    output logic overrun_q
);

    // Track whether a refresh is owed; a new expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= expire || (pending_q && !ref_fire);
        end
    end

    // Register the overrun event so the status pulse is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else begin
            overrun_q <= expire && pending_q && !ref_fire;
        end
    end

    // R8: an overrun pulse is only possible with a refresh already owed.
    p_overrun_needs_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |-> $past(pending_q));

    // R1: an accepted REF with no fresh expiry leaves nothing owed.
    p_ref_clears_owed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_fire && !expire) |=> !pending_q);

endmodule

// File: rtl/rpm_cmd_fsm.sv
// Command sequencer.
// From idle it runs one of two sequences:
//   refresh:   PALL, GAP_CYC NOP cycles, REF, back to idle;
//   low power: PALL, GAP_CYC NOP cycles, SREF or PDWN, park until the
//              clock-enable bit returns, then EXIT, back to idle.
// A command is held on the bus until cmd_ready accepts it.
// Idle waits while the access engine is busy. An owed refresh takes priority
// over a low-power entry.
// The SREF/PDWN choice is latched on entry from the refresh-enable bit.
// Assumes: GAP_CYC >= 1.
module rpm_cmd_fsm
    import rpm_pkg::*;
#(
    parameter int GAP_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_q,
    input  logic             ref_en_q,
    input  logic             pending,
    input  logic             busy,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [CMD_N-1:0] cmd_onehot,
    output logic             cke_out,
    output logic             ref_fire
);

    localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

    seq_state_e       state, state_nx;
    cmd_e             cmd_sel;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_done;
    logic             lp_sref_q;
    logic             fire;
    logic             in_gap;

    assign in_gap   = (state == S_RGAP) || (state == S_LGAP);
    assign gap_done = in_gap && (gap_cnt == GAP_LAST);
    assign fire     = cmd_valid && cmd_ready;
    assign ref_fire = fire && (state == S_REF);

    // Pick the command presented in the current state.
    always_comb begin
        unique case (state)
            S_RPALL, S_LPALL: cmd_sel = CMD_PALL;
            S_REF:            cmd_sel = CMD_REF;
            S_LENTER:         cmd_sel = lp_sref_q ? CMD_SREF : CMD_PDWN;
            S_EXIT:           cmd_sel = CMD_EXIT;
            default:          cmd_sel = CMD_NOP;
        endcase
    end

    assign cmd_valid  = (cmd_sel != CMD_NOP);
    assign cmd_onehot = cmd_to_onehot(cmd_sel);
    assign cke_out    = !((state == S_LENTER) || (state == S_SLEEP));

    // Next-state decision for both command sequences.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (!busy) begin
                    if (pending)     state_nx = S_RPALL;
                    else if (!cke_q) state_nx = S_LPALL;
                end
            end
            S_RPALL:  if (fire)     state_nx = S_RGAP;
            S_RGAP:   if (gap_done) state_nx = S_REF;
            S_REF:    if (fire)     state_nx = S_IDLE;
            S_LPALL:  if (fire)     state_nx = S_LGAP;
            S_LGAP:   if (gap_done) state_nx = S_LENTER;
            S_LENTER: if (fire)     state_nx = S_SLEEP;
            S_SLEEP:  if (cke_q)    state_nx = S_EXIT;
            S_EXIT:   if (fire)     state_nx = S_IDLE;
            default:                state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Count NOP cycles spent in either guard gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_gap) gap_cnt <= '0;
        else if (!gap_done)    gap_cnt <= gap_cnt + GAP_W'(1);
    end

    // Latch the low-power flavour as the entry command is about to show.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  lp_sref_q <= 1'b0;
        else if ((state == S_LGAP) && gap_done)      lp_sref_q <= ref_en_q;
    end

    // R9: an unaccepted command stays on the bus unchanged.
    p_hold_until_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_onehot)));

    // R1: an accepted PALL is followed by a NOP cycle.
    p_gap_after_pall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_onehot[CMD_PALL]) |=> !cmd_valid);

    // R5: CKE is low whenever a low-power entry command is presented.
    p_cke_low_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_onehot[CMD_SREF] || cmd_onehot[CMD_PDWN])) |-> !cke_out);

    // R2: idle is not left while a transfer is in flight.
    p_stay_idle_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE) && busy) |=> (state == S_IDLE));

    // R5: the exit command always carries CKE high.
    p_exit_cke_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_onehot[CMD_EXIT]) |-> cke_out);

endmodule

// File: rtl/sdram_rfsh_pm_seq.sv
// Top of the SDRAM refresh and power-mode sequencer.
// Ties the control register, the interval timer, the owed-refresh tracker
// and the command sequencer together.
// Assumes: the access engine holds xfer_busy high for the whole of any
// transfer, and the command consumer spaces commands by its own ready signal.
module sdram_rfsh_pm_seq
    import rpm_pkg::*;
#(
    parameter int                 CNT_W          = 16,
    parameter logic [CNT_W-1:0]   RESET_INTERVAL = CNT_W'(1560),
    parameter int                 GAP_CYC        = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_cke,
    input  logic             cfg_ref_en,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             xfer_busy,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [5:0]       cmd_onehot,
    output logic             cke_out,
    output logic             rfsh_overrun
);

    logic             cke_q;
    logic             ref_en_q;
    logic [CNT_W-1:0] interval_q;
    logic             expire;
    logic             pending_q;
    logic             ref_fire;

    rpm_cfg_regs #(
        .CNT_W          (CNT_W),
        .RESET_INTERVAL (RESET_INTERVAL)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_cke      (cfg_cke),
        .cfg_ref_en   (cfg_ref_en),
        .cfg_interval (cfg_interval),
        .cke_q        (cke_q),
        .ref_en_q     (ref_en_q),
        .interval_q   (interval_q)
    );

    rpm_interval_timer #(
        .CNT_W          (CNT_W),
        .RESET_INTERVAL (RESET_INTERVAL)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_ref_en   (cfg_ref_en),
        .cfg_interval (cfg_interval),
        .ref_en_q     (ref_en_q),
        .interval_q   (interval_q),
        .expire       (expire)
    );

    rpm_pending u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .ref_fire  (ref_fire),
        .pending_q (pending_q),
        .overrun_q (rfsh_overrun)
    );

    rpm_cmd_fsm #(
        .GAP_CYC (GAP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_q      (cke_q),
        .ref_en_q   (ref_en_q),
        .pending    (pending_q),
        .busy       (xfer_busy),
        .cmd_ready  (cmd_ready),
        .cmd_valid  (cmd_valid),
        .cmd_onehot (cmd_onehot),
        .cke_out    (cke_out),
        .ref_fire   (ref_fire)
    );

endmodule

// File: tb/sdram_rfsh_pm_seq_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for the refresh and power-mode sequencer.
// Inputs are driven and outputs sampled on falling edges. pcnt counts rising
// edges, so (pcnt - W) is the number of edges since the write captured at W.
module sdram_rfsh_pm_seq_tb_top;

    localparam int C_NOP = 0, C_PALL = 1, C_REF = 2, C_SREF = 3, C_PDWN = 4, C_EXIT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_cke = 1'b1;
    logic        cfg_ref_en = 1'b0;
    logic [15:0] cfg_interval = 16'd0;
    logic        xfer_busy = 1'b0;
    logic        cmd_ready = 1'b1;
    logic        cmd_valid;
    logic [5:0]  cmd_onehot;
    logic        cke_out;
    logic        rfsh_overrun;

    int n_cmp = 0;
    int n_mis = 0;
    int pcnt  = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) pcnt <= pcnt + 1;

    sdram_rfsh_pm_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_cke      (cfg_cke),
        .cfg_ref_en   (cfg_ref_en),
        .cfg_interval (cfg_interval),
        .xfer_busy    (xfer_busy),
        .cmd_ready    (cmd_ready),
        .cmd_valid    (cmd_valid),
        .cmd_onehot   (cmd_onehot),
        .cke_out      (cke_out),
        .rfsh_overrun (rfsh_overrun)
    );

    // Table: interval, busy length, expected offsets of first and second PALL.
    typedef struct packed {
        int n;
        int b;
        int e1;
        int e2;
    } vec_t;
    localparam vec_t VEC [5] = '{
        '{8,  0,  9, 17},
        '{8,  12, 12, 17},
        '{20, 5,  21, 41},
        '{5,  6,  6, 11},
        '{12, 13, 13, 25}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int is_cmd(input int c);
        return (cmd_valid && (cmd_onehot == (6'b1 << c))) ? 1 : 0;
    endfunction

    task automatic wr(input logic c, input logic r, input int iv, output int w);
        cfg_cke = c;
        cfg_ref_en = r;
        cfg_interval = iv[15:0];
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        w = pcnt;
    endtask

    task automatic wait_cmd(input int c, input int lim, output int s);
        s = 0;
        while (is_cmd(c) == 0 && s < lim) begin
            step();
            s++;
        end
        if (is_cmd(c) == 0) s = -1;
    endtask

    task automatic settle();
        int w;
        xfer_busy = 1'b0;
        cmd_ready = 1'b1;
        wr(1'b1, 1'b0, 100, w);
        repeat (10) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        int w, w0, s, off, cnt;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R10: reset state.
        chk("R10", "cmd_valid", cmd_valid, 0);
        chk("R10", "onehot NOP", cmd_onehot, 1);
        chk("R10", "cke_out", cke_out, 1);
        chk("R10", "overrun", rfsh_overrun, 0);

        // R7: refresh disabled out of reset, nothing is ever issued.
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            cnt += cmd_valid;
        end
        chk("R7", "commands while disabled", cnt, 0);

        // R1/R2: table of interval and busy patterns.
        for (int v = 0; v < 5; v++) begin
            int p1, p2, r1, gapnop;
            p1 = -1; p2 = -1; r1 = -1; gapnop = 0;
            xfer_busy = (VEC[v].b > 0);
            wr(1'b1, 1'b1, VEC[v].n, w);
            for (int i = 0; i < 120 && p2 < 0; i++) begin
                off = pcnt - w;
                if (VEC[v].b > 0 && off == VEC[v].b - 1) xfer_busy = 1'b0;
                if (p1 >= 0 && off == p1 + 1) gapnop = (cmd_valid == 1'b0);
                if (is_cmd(C_PALL) != 0) begin
                    if (p1 < 0) p1 = off;
                    else if (r1 >= 0) p2 = off;
                end
                if (is_cmd(C_REF) != 0 && p1 >= 0 && r1 < 0) r1 = off;
                if (p2 < 0) step();
            end
            chk(VEC[v].b > 0 ? "R2" : "R1", $sformatf("vec%0d first PALL", v), p1, VEC[v].e1);
            chk("R1", $sformatf("vec%0d REF after PALL", v), r1, p1 + 2);
            chk("R1", $sformatf("vec%0d NOP gap", v), gapnop, 1);
            chk("R2", $sformatf("vec%0d second PALL", v), p2, VEC[v].e2);
            settle();
        end

        // R9: stalled consumer keeps PALL on the bus.
        cmd_ready = 1'b0;
        wr(1'b1, 1'b1, 6, w);
        wait_cmd(C_PALL, 12, s);
        chk("R9", "stalled PALL shown", s >= 0, 1);
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            cnt += is_cmd(C_PALL);
        end
        chk("R9", "PALL held cycles", cnt, 4);
        cmd_ready = 1'b1;
        step();
        chk("R9", "NOP after accept", cmd_valid, 0);
        step();
        chk("R9", "REF after gap", is_cmd(C_REF), 1);
        settle();

        // R3/R5: self-refresh entry and exit.
        wr(1'b1, 1'b1, 200, w);
        step();
        wr(1'b0, 1'b1, 200, w);
        wait_cmd(C_PALL, 10, s);
        chk("R3", "PALL before SREF", s >= 0, 1);
        step();
        chk("R3", "gap NOP", cmd_valid, 0);
        chk("R5", "cke high in gap", cke_out, 1);
        step();
        chk("R3", "SREF issued", is_cmd(C_SREF), 1);
        chk("R5", "cke low on SREF", cke_out, 0);
        step();
        chk("R5", "cke low parked", cke_out, 0);
        chk("R5", "no command parked", cmd_valid, 0);
        repeat (5) step();
        wr(1'b1, 1'b1, 200, w);
        wait_cmd(C_EXIT, 4, s);
        chk("R5", "EXIT shown", s >= 0, 1);
        chk("R5", "cke high on EXIT", cke_out, 1);
        step();
        chk("R5", "idle after EXIT", cmd_valid, 0);
        settle();

        // R4: same write clears cke and refresh enable -> power-down.
        wr(1'b1, 1'b1, 200, w);
        step();
        wr(1'b0, 1'b0, 200, w);
        wait_cmd(C_PALL, 10, s);
        chk("R4", "PALL before PDWN", s >= 0, 1);
        step();
        chk("R4", "gap NOP", cmd_valid, 0);
        step();
        chk("R4", "PDWN issued", is_cmd(C_PDWN), 1);
        chk("R5", "cke low on PDWN", cke_out, 0);
        repeat (4) step();
        wr(1'b1, 1'b0, 200, w);
        wait_cmd(C_EXIT, 4, s);
        chk("R5", "EXIT from power-down", s >= 0, 1);
        settle();

        // R6: refresh owed from sleep is issued on wake.
        wr(1'b1, 1'b1, 10, w0);
        step();
        wr(1'b0, 1'b1, 10, w);
        repeat (28) step();
        wr(1'b1, 1'b1, 10, w);
        wait_cmd(C_EXIT, 4, s);
        chk("R6", "EXIT before owed refresh", s >= 0, 1);
        step();
        step();
        chk("R6", "PALL two cycles after EXIT", is_cmd(C_PALL), 1);
        step();
        step();
        chk("R6", "REF after wake PALL", is_cmd(C_REF), 1);
        settle();

        // R6: park and wake within one interval keeps the schedule.
        wr(1'b1, 1'b1, 40, w0);
        step();
        step();
        wr(1'b0, 1'b1, 40, w);
        repeat (8) step();
        wr(1'b1, 1'b1, 40, w);
        wait_cmd(C_PALL, 60, s);
        chk("R6", "PALL on schedule after short sleep", pcnt - w0, 41);
        settle();

        // R7: clear refresh enable while asleep, re-enable in the wake write.
        wr(1'b1, 1'b1, 300, w);
        step();
        wr(1'b0, 1'b1, 300, w);
        repeat (8) step();
        wr(1'b0, 1'b0, 300, w);
        repeat (5) step();
        wr(1'b1, 1'b1, 20, w0);
        cnt = 0;
        s = -1;
        for (int i = 0; i < 40 && s < 0; i++) begin
            cnt += is_cmd(C_EXIT);
            if (is_cmd(C_PALL) != 0) s = pcnt - w0;
            else step();
        end
        chk("R7", "EXIT seen on wake", cnt > 0, 1);
        chk("R7", "fresh interval after re-enable", s, 21);
        settle();

        // R8: busy held across two expiries gives one overrun pulse.
        xfer_busy = 1'b1;
        wr(1'b1, 1'b1, 6, w);
        cnt = 0;
        s = -1;
        for (int i = 0; i < 25; i++) begin
            off = pcnt - w;
            if (off == 13) xfer_busy = 1'b0;
            cnt += rfsh_overrun;
            if (s < 0 && is_cmd(C_PALL) != 0) s = off;
            step();
        end
        chk("R8", "overrun pulses", cnt, 1);
        chk("R2", "PALL after long busy", s, 14);
        settle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule